// File: doc/BRIEF.md
# Destination Address Hash Filter

This block decides whether a received Ethernet frame is accepted, looking only at its 48-bit destination address. The receive path presents the address together with a one-cycle strobe. One clock later the block returns an accept flag and a code that says which rule admitted the frame. The rules are:

- an exact compare against the programmed station address;
- a broadcast rule that can be switched off;
- a 64-entry hash table, used for group (multicast) and for individual (unicast) addresses under separate enables;
- a copy-all (promiscuous) mode.

The hash index is six bits wide. It is a fold of the address: every sixth address bit is XORed into the same index bit. The index then picks one bit of a table that arrives as two 32-bit words. Frame parsing, storage of configuration and any DMA are outside this block. All configuration arrives on plain input ports.

Address layout: byte k of the address, counted in the order it is received, occupies bits 8k+7 down to 8k. Bit 0 is therefore the group/individual indicator.

Top module: `dst_addr_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid`, `accept` and `match_kind` are all 0.
- R2: The result for an address strobed in cycle t appears in cycle t+1 with `out_valid`=1. In a cycle following one without a strobe, `out_valid`, `accept` and `match_kind` are all 0.
- R3: If the address equals the station address, the block accepts with `match_kind`=1. The station address is made of `station_lo` (bytes 0..3, byte 0 in bits 7:0) followed by `station_hi` (bytes 4..5, byte 4 in bits 7:0).
- R4: An all-ones address, with `cfg_no_bcast`=0, is accepted with `match_kind`=2.
- R5: With `cfg_no_bcast`=1, an all-ones address is rejected unless it is the station address or `cfg_copy_all`=1.
- R6: Hash index bit n (n=0..5) is the XOR of address bits n, n+6, ..., n+42. An index i below 32 selects `hash_lo[i]`; an index i of 32 or more selects `hash_hi[i-32]`.
- R7: A non-broadcast address with bit 0 = 1, `cfg_mcast_hash`=1 and the selected table bit set is accepted with `match_kind`=3.
- R8: An address with bit 0 = 0, `cfg_ucast_hash`=1 and the selected table bit set is accepted with `match_kind`=4.
- R9: An all-ones address never matches through the hash table. This holds even when the table is all ones and the multicast enable is on.
- R10: With `cfg_copy_all`=1 every strobed address is accepted. When no other rule matches, `match_kind`=5.
- R11: When several rules match, `match_kind` follows the priority station (1) > broadcast (2) > multicast hash (3) > unicast hash (4) > copy-all (5). The value 0 means no match.
- R12: Whenever `out_valid`=1, `accept` is 1 exactly when `match_kind` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dst_valid | input | 1 | Strobe: `dst_addr` holds a destination address |
| dst_addr | input | 48 | Destination address, byte k in bits 8k+7:8k |
| station_lo | input | 32 | Station address bytes 0..3 |
| station_hi | input | 16 | Station address bytes 4..5 |
| hash_lo | input | 32 | Hash table entries 0..31 |
| hash_hi | input | 32 | Hash table entries 32..63 |
| cfg_copy_all | input | 1 | Accept every frame |
| cfg_no_bcast | input | 1 | Reject the all-ones address |
| cfg_mcast_hash | input | 1 | Enable hash matching of group addresses |
| cfg_ucast_hash | input | 1 | Enable hash matching of individual addresses |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| accept | output | 1 | Frame accepted |
| match_kind | output | 3 | Rule that matched: 0 none, 1 station, 2 broadcast, 3 multicast hash, 4 unicast hash, 5 copy-all |

## Verification
The interesting same-cycle collisions pair the broadcast rule with the multicast hash rule, and the station compare with a hash hit.

- Broadcast against hash: an all-ones address is driven while the table is full and the multicast enable is on. It must report broadcast, and it must be rejected once broadcasts are barred.
- Station against hash: a group address is programmed as the station address and its own hash bit is set. Both rules hit, and the code must still name the station rule.

A behavioural model in the bench recomputes the fold and the priority for every strobe and judges each cycle's outputs. A long random phase mixes all four enables so that these collisions also occur unplanned.

// File: rtl/daf_pkg.sv
// Package: shared constants and the match-kind encoding of the
// destination address filter. Assumes the encoding is fixed, because the
// receive path downstream decodes match_kind.
package daf_pkg;

    // Width of the station address low word (bytes 0..3)
    localparam int STA_LO_W = 32;

    // Rule that admitted a frame; the values are visible on match_kind
    typedef enum logic [2:0] {
        MK_NONE     = 3'd0,
        MK_STATION  = 3'd1,
        MK_BCAST    = 3'd2,
        MK_MCAST    = 3'd3,
        MK_UCAST    = 3'd4,
        MK_COPY_ALL = 3'd5
    } match_kind_e;

endpackage

// File: rtl/daf_fold_index.sv
// Module: daf_fold_index
// Folds a destination address into a hash index. Index bit n is the XOR
// of every address bit whose position is congruent to n modulo IDX_W.
// Assumes ADDR_W is a whole multiple of IDX_W. Purely combinational.
module daf_fold_index #(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int FOLDS = ADDR_W / IDX_W;

    for (genvar n = 0; n < IDX_W; n++) begin : g_bit
        // XOR of the address bits that land on index bit n
        always_comb begin
            idx[n] = 1'b0;
            for (int k = 0; k < FOLDS; k++) begin
                idx[n] = idx[n] ^ addr[n + k*IDX_W];
            end
        end
    end

endmodule

// File: rtl/daf_table_pick.sv
// Module: daf_table_pick
// Selects one bit of the hash table held as two equal words. The top
// index bit chooses the word and the remaining bits choose the bit
// within it. Assumes IDX_W >= 2. Purely combinational.
module daf_table_pick #(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0]            idx,
    input  logic [((1<<IDX_W)/2)-1:0]   tbl_lo,
    input  logic [((1<<IDX_W)/2)-1:0]   tbl_hi,
    output logic                        bit_set
);
    localparam int SUB_W = IDX_W - 1;

    logic [((1<<IDX_W)/2)-1:0] word_sel;
    logic [SUB_W-1:0]          sub_idx;

    // Choose the word from the top index bit, then the bit inside it
    always_comb begin
        word_sel = idx[IDX_W-1] ? tbl_hi : tbl_lo;
        sub_idx  = idx[SUB_W-1:0];
        bit_set  = word_sel[sub_idx];
    end

endmodule

// File: rtl/daf_station_cmp.sv
// Module: daf_station_cmp
// Byte-wise comparator. It reports an exact match against the station
// address and detects the all-ones broadcast address. Assumes ADDR_W is a
// whole number of bytes. Purely combinational.
module daf_station_cmp #(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] station,
    output logic              sta_hit,
    output logic              is_bcast
);
    localparam int NBYTES = ADDR_W / 8;

    logic [NBYTES-1:0] byte_eq;
    logic [NBYTES-1:0] byte_ones;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        // Per-byte equality with the station and all-ones detection
        always_comb begin
            byte_eq[b]   = (addr[b*8 +: 8] == station[b*8 +: 8]);
            byte_ones[b] = &addr[b*8 +: 8];
        end
    end

    // Reduce the per-byte results to the two flags
    always_comb begin
        sta_hit  = &byte_eq;
        is_bcast = &byte_ones;
    end

endmodule

// File: rtl/daf_rule_prio.sv
// Module: daf_rule_prio
// Combines the individual rule hits into an accept decision and a
// prioritised match code. The accept decision is formed as an OR of the
// rule hits, independently of the encoder. Assumes all inputs are already
// qualified by the address strobe upstream. Purely combinational.
module daf_rule_prio
    import daf_pkg::*;
(
    input  logic        sta_hit,
    input  logic        is_bcast,
    input  logic        grp_bit,
    input  logic        tbl_bit,
    input  logic        copy_all,
    input  logic        no_bcast,
    input  logic        mcast_en,
    input  logic        ucast_en,
    output match_kind_e kind,
    output logic        acc
);
    logic bc_ok;
    logic mc_ok;
    logic uc_ok;

    // Qualify each rule; broadcast is kept out of the hash path
    always_comb begin
        bc_ok = is_bcast & ~no_bcast;
        mc_ok = ~is_bcast & grp_bit & mcast_en & tbl_bit;
        uc_ok = ~grp_bit & ucast_en & tbl_bit;
    end

    // Priority encoder: station, broadcast, multicast, unicast, copy-all
    always_comb begin
        if (sta_hit)        kind = MK_STATION;
        else if (bc_ok)     kind = MK_BCAST;
        else if (mc_ok)     kind = MK_MCAST;
        else if (uc_ok)     kind = MK_UCAST;
        else if (copy_all)  kind = MK_COPY_ALL;
        else                kind = MK_NONE;
    end

    // Accept when any rule admits the frame
    always_comb begin
        acc = sta_hit | bc_ok | mc_ok | uc_ok | copy_all;
    end

endmodule

// File: rtl/dst_addr_filter.sv
// Module: dst_addr_filter
// Destination address filter. It decides, one cycle after the address
// strobe, whether a frame is accepted and which rule admitted it. Assumes
// the configuration inputs are stable around the strobe and that ADDR_W
// is a multiple of both 8 and IDX_W.
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         dst_valid,
    input  logic [ADDR_W-1:0]            dst_addr,
    input  logic [STA_LO_W-1:0]          station_lo,
    input  logic [ADDR_W-STA_LO_W-1:0]   station_hi,
    input  logic [((1<<IDX_W)/2)-1:0]    hash_lo,
    input  logic [((1<<IDX_W)/2)-1:0]    hash_hi,
    input  logic                         cfg_copy_all,
    input  logic                         cfg_no_bcast,
    input  logic                         cfg_mcast_hash,
    input  logic                         cfg_ucast_hash,
    output logic                         out_valid,
    output logic                         accept,
    output logic [2:0]                   match_kind
);
    logic [ADDR_W-1:0] station;
    logic [IDX_W-1:0]  hash_idx;
    logic              tbl_bit;
    logic              sta_hit;
    logic              is_bcast;
    match_kind_e       kind_c;
    logic              acc_c;

    // Assemble the station address, low word first
    always_comb begin
        station = {station_hi, station_lo};
    end

    daf_fold_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_fold (
        .addr (dst_addr),
        .idx  (hash_idx)
    );

    daf_table_pick #(.IDX_W(IDX_W)) i_pick (
        .idx     (hash_idx),
        .tbl_lo  (hash_lo),
        .tbl_hi  (hash_hi),
        .bit_set (tbl_bit)
    );

    daf_station_cmp #(.ADDR_W(ADDR_W)) i_cmp (
        .addr     (dst_addr),
        .station  (station),
        .sta_hit  (sta_hit),
        .is_bcast (is_bcast)
    );

    daf_rule_prio i_prio (
        .sta_hit  (sta_hit),
        .is_bcast (is_bcast),
        .grp_bit  (dst_addr[0]),
        .tbl_bit  (tbl_bit),
        .copy_all (cfg_copy_all),
        .no_bcast (cfg_no_bcast),
        .mcast_en (cfg_mcast_hash),
        .ucast_en (cfg_ucast_hash),
        .kind     (kind_c),
        .acc      (acc_c)
    );

    // Result register: capture the decision on a strobe, clear otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            accept     <= 1'b0;
            match_kind <= MK_NONE;
        end else if (dst_valid) begin
            out_valid  <= 1'b1;
            accept     <= acc_c;
            match_kind <= kind_c;
        end else begin
            out_valid  <= 1'b0;
            accept     <= 1'b0;
            match_kind <= MK_NONE;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid |=> out_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_valid |=> (!out_valid && !accept && match_kind == 3'd0));

    // R12
    accept_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (accept == (match_kind != 3'd0)));

    // R10
    copy_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && cfg_copy_all) |=> accept);

    // R3
    station_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && dst_addr == {station_hi, station_lo}) |=> (match_kind == 3'd1));

    // R5
    no_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && (&dst_addr) && cfg_no_bcast && !cfg_copy_all &&
         dst_addr != {station_hi, station_lo}) |=> !accept);

    // R6 (every address bit feeds exactly one index bit, so parities agree)
    fold_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid |-> ((^hash_idx) == (^dst_addr)));

    // R9
    bcast_no_hash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && (&dst_addr)) |=> (match_kind != 3'd3 && match_kind != 3'd4));

endmodule

// File: tb/test_dst_addr_filter.sv
module test_dst_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        d_valid = 1'b0;
    logic [47:0] d_addr = '0;
    logic [31:0] d_sta_lo = '0;
    logic [15:0] d_sta_hi = '0;
    logic [31:0] d_hlo = '0;
    logic [31:0] d_hhi = '0;
    logic        d_ca = 1'b0, d_nb = 1'b0, d_mc = 1'b0, d_uc = 1'b0;

    // next-cycle configuration, applied together with the address
    logic [31:0] nx_sta_lo = '0;
    logic [15:0] nx_sta_hi = '0;
    logic [31:0] nx_hlo = '0;
    logic [31:0] nx_hhi = '0;
    logic        nx_ca = 1'b0, nx_nb = 1'b0, nx_mc = 1'b0, nx_uc = 1'b0;

    logic        out_valid, accept;
    logic [2:0]  match_kind;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expectation for the outputs at the next sampling point
    logic       e_valid = 1'b0;
    logic       e_acc = 1'b0;
    int         e_kind = 0;
    string      e_tag = "R1";

    always #4 clk = ~clk;

    dst_addr_filter i_dst_addr_filter (
        .clk(clk), .rst_n(rst_n), .dst_valid(d_valid), .dst_addr(d_addr),
        .station_lo(d_sta_lo), .station_hi(d_sta_hi),
        .hash_lo(d_hlo), .hash_hi(d_hhi),
        .cfg_copy_all(d_ca), .cfg_no_bcast(d_nb),
        .cfg_mcast_hash(d_mc), .cfg_ucast_hash(d_uc),
        .out_valid(out_valid), .accept(accept), .match_kind(match_kind)
    );

    // Reference hash index: bit n is XOR of address bits n + 6k
    function automatic int ref_index(input logic [47:0] a);
        int r = 0;
        for (int n = 0; n < 6; n++) begin
            int b = 0;
            for (int k = 0; k < 8; k++) b = b ^ int'(a[n + 6*k]);
            r = r | (b << n);
        end
        return r;
    endfunction

    // Reference decision from the rules and their priority
    function automatic int ref_kind(input logic [47:0] a);
        int  i = ref_index(a);
        bit  tb = (i < 32) ? nx_hlo[i] : nx_hhi[i-32];
        bit  bc = (a == {48{1'b1}});
        if (a == {nx_sta_hi, nx_sta_lo}) return 1;
        if (bc && !nx_nb) return 2;
        if (!bc && a[0] && nx_mc && tb) return 3;
        if (!a[0] && nx_uc && tb) return 4;
        if (nx_ca) return 5;
        return 0;
    endfunction

    // One clock: judge the previous cycle, then apply new inputs
    task automatic step(input logic v, input logic [47:0] a, input string tag);
        @(negedge clk);
        checks++;
        if (out_valid !== e_valid || accept !== e_acc || int'(match_kind) != e_kind) begin
            errors++;
            $display("FAIL %s: valid/accept/kind = %0b/%0b/%0d, expected %0b/%0b/%0d",
                     e_tag, out_valid, accept, match_kind, e_valid, e_acc, e_kind);
        end
        d_valid  = v;
        d_addr   = a;
        d_sta_lo = nx_sta_lo; d_sta_hi = nx_sta_hi;
        d_hlo    = nx_hlo;    d_hhi    = nx_hhi;
        d_ca = nx_ca; d_nb = nx_nb; d_mc = nx_mc; d_uc = nx_uc;
        e_valid = v;
        e_kind  = v ? ref_kind(a) : 0;
        e_acc   = (e_kind != 0);
        e_tag   = tag;
    endtask

    // Set the single table bit selected by an address
    task automatic set_bit_for(input logic [47:0] a);
        int i = ref_index(a);
        nx_hlo = '0; nx_hhi = '0;
        if (i < 32) nx_hlo[i] = 1'b1; else nx_hhi[i-32] = 1'b1;
    endtask

    function automatic logic [47:0] rnd48();
        return {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [47:0] a;
        // R1: reset with a strobe pending; outputs must stay zero
        d_valid = 1'b1; d_addr = '1; d_ca = 1'b1;
        nx_ca = 1'b1;
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0 || accept !== 1'b0 || match_kind !== 3'd0) begin
                errors++;
                $display("FAIL R1: valid/accept/kind = %0b/%0b/%0d, expected 0/0/0",
                         out_valid, accept, match_kind);
            end
        end
        d_valid = 1'b0; nx_ca = 1'b0; d_ca = 1'b0;
        rst_n = 1'b1;
        e_valid = 0; e_acc = 0; e_kind = 0; e_tag = "R1";

        // R3: station address bytes, low word first
        nx_sta_lo = 32'h4433_2211; nx_sta_hi = 16'h6655;
        step(1'b0, '0, "R2");
        step(1'b1, 48'h6655_4433_2211, "R3");
        step(1'b1, 48'h6655_4433_2210, "R3");   // one bit off: reject
        step(1'b1, 48'h6654_4433_2211, "R3");   // top byte off: reject
        step(1'b0, 48'h6655_4433_2211, "R2");   // no strobe: quiet

        // R4 / R5: broadcast allowed, then barred, then copy-all
        step(1'b1, '1, "R4");
        nx_nb = 1'b1;
        step(1'b1, '1, "R5");
        nx_ca = 1'b1;
        step(1'b1, '1, "R10");
        nx_ca = 1'b0;

        // R9: full table and multicast enable do not admit broadcast
        nx_hlo = '1; nx_hhi = '1; nx_mc = 1'b1; nx_uc = 1'b1;
        step(1'b1, '1, "R9");
        nx_nb = 1'b0;
        step(1'b1, '1, "R9");

        // R10 / R7: full table accepts every multicast address
        for (int j = 0; j < 20; j++) step(1'b1, rnd48() | 48'h1, "R7");

        // R7 / R8 / R6: sweep every index with a one-hot table
        for (int i = 0; i < 64; i++) begin
            do a = rnd48(); while (ref_index(a) != i);
            a[0] = 1'b0;  // clear group bit; ref index changes so recompute
            set_bit_for(a | 48'h1);
            nx_mc = 1'b1; nx_uc = 1'b0;
            step(1'b1, a | 48'h1, "R7");
            set_bit_for(a);
            nx_mc = 1'b0; nx_uc = 1'b1;
            step(1'b1, a, "R8");
            nx_uc = 1'b0;
            step(1'b1, a, "R8");                 // enable off: reject
            nx_uc = 1'b1; nx_hlo = ~nx_hlo; nx_hhi = ~nx_hhi;
            step(1'b1, a, "R6");                 // every other bit set: reject
        end

        // R11: station that is a group address with its hash bit set
        nx_sta_lo = 32'h0302_0101; nx_sta_hi = 16'h0504;
        set_bit_for(48'h0504_0302_0101);
        nx_mc = 1'b1; nx_ca = 1'b1;
        step(1'b1, 48'h0504_0302_0101, "R11");
        nx_sta_lo = 32'h0; nx_sta_hi = 16'h0;
        step(1'b1, 48'h0504_0302_0101, "R11");  // multicast over copy-all
        nx_hlo = '0; nx_hhi = '0;
        step(1'b1, 48'h0504_0302_0101, "R10");  // only copy-all left
        nx_sta_lo = '1; nx_sta_hi = '1; nx_nb = 1'b1;
        step(1'b1, '1, "R11");                   // station beats the bar
        nx_ca = 1'b0; nx_nb = 1'b0; nx_mc = 1'b0;

        // R12 / R2: random mix with gaps in the strobe
        for (int j = 0; j < 3000; j++) begin
            if ($urandom_range(0, 7) == 0) begin
                nx_sta_lo = $urandom(); nx_sta_hi = 16'($urandom());
                nx_hlo = $urandom(); nx_hhi = $urandom();
                {nx_ca, nx_nb, nx_mc, nx_uc} = 4'($urandom());
            end
            case ($urandom_range(0, 5))
                0: a = '1;
                1: a = {nx_sta_hi, nx_sta_lo};
                default: a = rnd48();
            endcase
            step(1'($urandom_range(0, 3) != 0), a, "R12");
        end
        step(1'b0, '0, "R2");
        step(1'b0, '0, "R2");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule